// File: doc/BRIEF.md
# Protected Down-Counting Timer with Clock Prescaler

This block is a programmable down-counter that a processor reaches over a small register bus with single-cycle accesses. Three registers are visible: a mode register, a live count register and a reload register. Every write carries a flag that says whether it comes from user mode or from privileged mode. A protect bit in the mode register decides what happens to user-mode writes. When it is clear, they are accepted. When it is set, they are dropped and a one-cycle rejection pulse is raised. Privileged writes are always accepted, and reads work from either mode. The inverse of the protect bit is driven out so that a neighbouring watchdog can apply the same rule to its own control and setup registers.

The counter does not get a derived clock. It advances on a clock-enable tick made in the bus clock domain. A two-bit select field sets the tick rate to the bus clock divided by 1, 4, 8 or 16. On each tick while counting is enabled, the count decrements. When the count is at zero, the next tick produces a one-cycle terminal pulse. The counter then either reloads or stops and clears its own enable. A synchronous soft reset input clears the block in the same way as the hardware reset.

Top module: `priv_timer`

## Requirements
- R1: After reset, the mode, count and reload registers read 0, `wdog_user_wr_ok` is 1 and `tick` is high in every cycle.
- R2: Register addresses are mode=0, count=1 and reload=2. While mode bit 3 (protect) is 0, a user-mode write (`bus_user`=1) updates the addressed register, and `wr_reject` stays 0.
- R3: While protect is 1, a user-mode write to any of the three registers leaves every register unchanged. `wr_reject` is then high for exactly the one cycle that follows the write edge.
- R4: A privileged write (`bus_user`=0) updates the addressed register whatever the protect bit holds.
- R5: `bus_rdata` shows the register chosen by `bus_addr` combinationally and does not depend on `bus_user`. Mode bits sit in rdata[5:0] and the upper bits read 0.
- R6: `wdog_user_wr_ok` is 1 exactly when the protect bit is 0.
- R7: Mode bits 5:4 select the tick rate: 00 gives every cycle, 01 gives one cycle in 4, 10 gives one in 8 and 11 gives one in 16. An accepted mode write restarts the prescaler, so the first tick comes N-1 cycles after the write edge, where N is the divisor.
- R8: While mode bit 0 (enable) is 1, each tick decrements a nonzero count. A tick that finds the count at 0 raises `tc_pulse` for one cycle, starting at the following edge.
- R9: At that terminal tick, if mode bit 1 (auto-reload) is 1, the count loads the reload value. If it is 0, the count stays 0 and mode bit 0 clears.
- R10: An accepted write to the count register in the same cycle as an enabled tick stores the written value without a decrement.
- R11: A one-cycle `soft_rst` clears all three registers and the prescaler, so `wdog_user_wr_ok` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| soft_rst | input | 1 | Synchronous software reset, active high |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_user | input | 1 | 1 = write issued from user mode, 0 = privileged |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data for `bus_addr` |
| tick | output | 1 | Prescaled clock-enable tick |
| tc_pulse | output | 1 | One-cycle terminal-count pulse |
| wr_reject | output | 1 | One-cycle pulse after a dropped user write |
| wdog_user_wr_ok | output | 1 | User-mode write permission for the watchdog registers |

## Verification
The properties assume that `bus_wr` is a single-cycle strobe, that `bus_addr`, `bus_user` and `bus_wdata` are steady around the clock edge, and that `soft_rst` never comes in the same cycle as a write that a property follows. The properties that track writes exclude the soft-reset case explicitly. The stimulus changes inputs only on falling edges, holds each write for exactly one cycle, and issues soft reset only when the bus is idle. The counter tests run with enable set and no bus writes, except the single count write that probes the write-versus-tick priority.

// File: rtl/priv_timer_pkg.sv
package priv_timer_pkg;

  localparam int MODE_W     = 6;
  localparam int MB_EN      = 0;
  localparam int MB_AUTO    = 1;
  localparam int MB_PROT    = 3;
  localparam int MB_CSEL_LO = 4;
  localparam int PS_W       = 4;

  typedef enum logic [1:0] {
    A_MODE   = 2'd0,
    A_COUNT  = 2'd1,
    A_RELOAD = 2'd2,
    A_NONE   = 2'd3
  } reg_addr_e;

  // divisor minus one for a select code
  function automatic logic [PS_W-1:0] ps_limit(input logic [1:0] sel);
    logic [PS_W-1:0] lim;
    case (sel)
      2'b00:   lim = PS_W'(0);
      2'b01:   lim = PS_W'(3);
      2'b10:   lim = PS_W'(7);
      default: lim = PS_W'(15);
    endcase
    return lim;
  endfunction

endpackage

// File: rtl/ptmr_access.sv
module ptmr_access
  import priv_timer_pkg::*;
(
  input  logic       bus_wr,
  input  logic       bus_user,
  input  logic [1:0] bus_addr,
  input  logic       protect,
  input  logic       soft_rst,
  output logic       we_mode,
  output logic       we_count,
  output logic       we_reload,
  output logic       rejected
);
  logic allowed;

  always_comb begin
    allowed   = bus_wr & ~soft_rst & (~bus_user | ~protect);
    rejected  = bus_wr & ~soft_rst & bus_user & protect;
    we_mode   = allowed & (bus_addr == A_MODE);
    we_count  = allowed & (bus_addr == A_COUNT);
    we_reload = allowed & (bus_addr == A_RELOAD);
  end
endmodule

// File: rtl/ptmr_prescale.sv
module ptmr_prescale
  import priv_timer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       restart,
  input  logic [1:0] csel,
  output logic       tick
);
  logic [PS_W-1:0] pc_q, pc_d;
  logic [PS_W-1:0] limit;

  always_comb begin
    limit = ps_limit(csel);
    tick  = (pc_q == limit);
    if (clr || restart) pc_d = '0;
    else if (tick)      pc_d = '0;
    else                pc_d = pc_q + PS_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end
endmodule

// File: rtl/ptmr_counter.sv
module ptmr_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic             auto_rl,
  input  logic             tick,
  input  logic             we_count,
  input  logic [CNT_W-1:0] wdata,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] count,
  output logic             tc_pulse,
  output logic             stop_req
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             tc_q, tc_d;
  logic             dec_ev;

  always_comb begin
    dec_ev   = en & tick & ~we_count & ~clr;
    cnt_d    = cnt_q;
    tc_d     = 1'b0;
    stop_req = 1'b0;
    if (clr) begin
      cnt_d = '0;
    end else if (we_count) begin
      cnt_d = wdata;
    end else if (dec_ev) begin
      if (cnt_q == '0) begin
        tc_d = 1'b1;
        if (auto_rl) cnt_d    = reload;
        else         stop_req = 1'b1;
      end else begin
        cnt_d = cnt_q - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tc_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      tc_q  <= tc_d;
    end
  end

  assign count    = cnt_q;
  assign tc_pulse = tc_q;
endmodule

// File: rtl/ptmr_regs.sv
module ptmr_regs
  import priv_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              we_mode,
  input  logic              we_reload,
  input  logic              stop_req,
  input  logic [CNT_W-1:0]  wdata,
  input  logic [1:0]        rd_addr,
  input  logic [CNT_W-1:0]  count,
  output logic [MODE_W-1:0] mode,
  output logic [CNT_W-1:0]  reload,
  output logic [CNT_W-1:0]  rdata
);
  logic [MODE_W-1:0] mode_q, mode_d;
  logic [CNT_W-1:0]  rl_q, rl_d;

  always_comb begin
    mode_d = mode_q;
    rl_d   = rl_q;
    if (clr) begin
      mode_d = '0;
      rl_d   = '0;
    end else begin
      if (we_mode)       mode_d        = wdata[MODE_W-1:0];
      else if (stop_req) mode_d[MB_EN] = 1'b0;
      if (we_reload)     rl_d          = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      rl_q   <= '0;
    end else begin
      mode_q <= mode_d;
      rl_q   <= rl_d;
    end
  end

  always_comb begin
    case (rd_addr)
      A_MODE:   rdata = {{(CNT_W-MODE_W){1'b0}}, mode_q};
      A_COUNT:  rdata = count;
      A_RELOAD: rdata = rl_q;
      default:  rdata = '0;
    endcase
  end

  assign mode   = mode_q;
  assign reload = rl_q;
endmodule

// File: rtl/priv_timer.sv
module priv_timer
  import priv_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             bus_wr,
  input  logic             bus_user,
  input  logic [1:0]       bus_addr,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  output logic             tick,
  output logic             tc_pulse,
  output logic             wr_reject,
  output logic             wdog_user_wr_ok
);
  logic              rst_meta, rst_q;
  logic              we_mode, we_count, we_reload, rejected;
  logic              rej_q;
  logic              stop_req;
  logic [MODE_W-1:0] mode_q;
  logic [CNT_W-1:0]  reload_q, count_q;

  // async assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  ptmr_access u_access (
    .bus_wr    (bus_wr),
    .bus_user  (bus_user),
    .bus_addr  (bus_addr),
    .protect   (mode_q[MB_PROT]),
    .soft_rst  (soft_rst),
    .we_mode   (we_mode),
    .we_count  (we_count),
    .we_reload (we_reload),
    .rejected  (rejected)
  );

  ptmr_regs #(.CNT_W(CNT_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_q),
    .clr       (soft_rst),
    .we_mode   (we_mode),
    .we_reload (we_reload),
    .stop_req  (stop_req),
    .wdata     (bus_wdata),
    .rd_addr   (bus_addr),
    .count     (count_q),
    .mode      (mode_q),
    .reload    (reload_q),
    .rdata     (bus_rdata)
  );

  ptmr_prescale u_ps (
    .clk     (clk),
    .rst_n   (rst_q),
    .clr     (soft_rst),
    .restart (we_mode),
    .csel    (mode_q[MB_CSEL_LO+1:MB_CSEL_LO]),
    .tick    (tick)
  );

  ptmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_q),
    .clr      (soft_rst),
    .en       (mode_q[MB_EN]),
    .auto_rl  (mode_q[MB_AUTO]),
    .tick     (tick),
    .we_count (we_count),
    .wdata    (bus_wdata),
    .reload   (reload_q),
    .count    (count_q),
    .tc_pulse (tc_pulse),
    .stop_req (stop_req)
  );

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) rej_q <= 1'b0;
    else        rej_q <= rejected;
  end

  assign wr_reject       = rej_q;
  assign wdog_user_wr_ok = ~mode_q[MB_PROT];
endmodule

// File: rtl/ptmr_chk.sv
module ptmr_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_q,
  input logic             soft_rst,
  input logic             bus_wr,
  input logic             bus_user,
  input logic [1:0]       bus_addr,
  input logic [CNT_W-1:0] bus_wdata,
  input logic [5:0]       mode_q,
  input logic [CNT_W-1:0] count_q,
  input logic [CNT_W-1:0] reload_q,
  input logic             tick,
  input logic             tc_pulse,
  input logic             wr_reject,
  input logic             wdog_user_wr_ok
);
  // R3
  dropped_hold_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (bus_wr && bus_user && mode_q[3] && !soft_rst) |=> ($stable(reload_q) && $stable(mode_q)));

  // R3
  reject_pulse_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (bus_wr && bus_user && mode_q[3] && !soft_rst) |=> wr_reject);

  // R4
  priv_reload_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (bus_wr && !bus_user && bus_addr == 2'd2 && !soft_rst) |=> (reload_q == $past(bus_wdata)));

  // R8
  tc_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_q)
    tc_pulse |-> ($past(count_q) == '0));

  // R10
  count_wr_prio_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (bus_wr && bus_addr == 2'd1 && (!bus_user || !mode_q[3]) && !soft_rst)
      |=> (count_q == $past(bus_wdata)));

  // R11
  soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_q)
    soft_rst |=> (mode_q == 6'd0 && count_q == '0 && wdog_user_wr_ok));

  // R7
  full_rate_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (mode_q[5:4] == 2'b00) |-> tick);
endmodule

bind priv_timer ptmr_chk #(.CNT_W(CNT_W)) u_chk (
  .clk             (clk),
  .rst_q           (rst_q),
  .soft_rst        (soft_rst),
  .bus_wr          (bus_wr),
  .bus_user        (bus_user),
  .bus_addr        (bus_addr),
  .bus_wdata       (bus_wdata),
  .mode_q          (mode_q),
  .count_q         (count_q),
  .reload_q        (reload_q),
  .tick            (tick),
  .tc_pulse        (tc_pulse),
  .wr_reject       (wr_reject),
  .wdog_user_wr_ok (wdog_user_wr_ok)
);

// File: tb/tb_priv_timer.sv
module tb_priv_timer;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n, soft_rst, bus_wr, bus_user;
  logic [1:0]   bus_addr;
  logic [W-1:0] bus_wdata, bus_rdata;
  logic         tick, tc_pulse, wr_reject, wdog_user_wr_ok;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  priv_timer #(.CNT_W(W)) dut (
    .clk (clk), .rst_n (rst_n), .soft_rst (soft_rst),
    .bus_wr (bus_wr), .bus_user (bus_user), .bus_addr (bus_addr),
    .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .tick (tick),
    .tc_pulse (tc_pulse), .wr_reject (wr_reject),
    .wdog_user_wr_ok (wdog_user_wr_ok)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // drive at a falling edge, write at the next rising edge, return at the falling edge after it
  task automatic wr(input logic [1:0] a, input logic [W-1:0] d, input logic user);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_user = user;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic user, output logic [W-1:0] d);
    bus_addr = a; bus_user = user;
    #1 d = bus_rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [W-1:0] v;
    logic [W-1:0] snap [3];
    rst_n = 1'b0; soft_rst = 1'b0; bus_wr = 1'b0; bus_user = 1'b0;
    bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd(2'd0, 1'b0, v); chk("R1 mode", v, 0);
    rd(2'd1, 1'b0, v); chk("R1 count", v, 0);
    rd(2'd2, 1'b0, v); chk("R1 reload", v, 0);
    chk("R1 wdog", wdog_user_wr_ok, 1);
    chk("R1 tick", tick, 1);

    // R2 unprotected user writes
    wr(2'd2, 16'h1234, 1'b1); chk("R2 reject", wr_reject, 0);
    wr(2'd1, 16'h0055, 1'b1);
    wr(2'd0, 16'h0004, 1'b1);
    rd(2'd2, 1'b1, v); chk("R2 reload", v, 16'h1234);
    rd(2'd1, 1'b1, v); chk("R2 count", v, 16'h0055);
    rd(2'd0, 1'b1, v); chk("R2 mode", v, 16'h0004);

    // R6 set protect from user mode while still allowed
    wr(2'd0, 16'h0008, 1'b1);
    chk("R6 wdog protected", wdog_user_wr_ok, 0);

    // R3 dropped user writes to every register
    for (int a = 0; a < 3; a++) begin
      wr(2'(a), 16'hFFFF, 1'b1);
      chk("R3 reject pulse", wr_reject, 1);
      @(negedge clk);
      chk("R3 reject single", wr_reject, 0);
      rd(2'd0, 1'b0, v); chk("R3 mode kept", v, 16'h0008);
      rd(2'd1, 1'b0, v); chk("R3 count kept", v, 16'h0055);
      rd(2'd2, 1'b0, v); chk("R3 reload kept", v, 16'h1234);
    end

    // R5 reads match from both modes
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), 1'b0, snap[0]);
      rd(2'(a), 1'b1, v);
      chk("R5 read mode-independent", v, snap[0]);
    end
    rd(2'd3, 1'b1, v); chk("R5 unused addr", v, 0);

    // R4 privileged writes under protection
    wr(2'd2, 16'h00AA, 1'b0); chk("R4 no reject", wr_reject, 0);
    wr(2'd1, 16'h0003, 1'b0);
    rd(2'd2, 1'b1, v); chk("R4 reload", v, 16'h00AA);
    rd(2'd1, 1'b1, v); chk("R4 count", v, 16'h0003);
    wr(2'd0, 16'h0000, 1'b0);
    chk("R4/R6 unprotect", wdog_user_wr_ok, 1);

    // R7 tick period sweep
    for (int c = 0; c < 4; c++) begin
      int n, cnt, first;
      n = (c == 0) ? 1 : (c == 1) ? 4 : (c == 2) ? 8 : 16;
      wr(2'd0, W'(c << 4), 1'b0);
      cnt = 0; first = -1;
      for (int i = 0; i < 64; i++) begin
        if (tick) begin
          cnt++;
          if (first < 0) first = i;
        end
        @(negedge clk);
      end
      chk("R7 tick count", cnt, 64 / n);
      chk("R7 first tick", first, n - 1);
    end

    // R8/R9 auto-reload
    wr(2'd2, 16'd3, 1'b0);
    wr(2'd1, 16'd3, 1'b0);
    wr(2'd0, 16'h0003, 1'b0);
    bus_addr = 2'd1;
    for (int i = 0; i < 40; i++) begin
      #1;
      chk("R8/R9 reload count", bus_rdata, 3 - (i % 4));
      chk("R8 tc", tc_pulse, (i > 0 && i % 4 == 0));
      @(negedge clk);
    end
    wr(2'd0, 16'h0000, 1'b0);

    // R9 one-shot
    wr(2'd1, 16'd2, 1'b0);
    wr(2'd0, 16'h0001, 1'b0);
    bus_addr = 2'd1;
    for (int i = 0; i < 10; i++) begin
      #1;
      chk("R9 one-shot count", bus_rdata, (i < 2) ? 2 - i : 0);
      chk("R9 one-shot tc", tc_pulse, (i == 3));
      @(negedge clk);
    end
    rd(2'd0, 1'b0, v); chk("R9 enable cleared", v, 0);

    // R10 count write beats a tick
    wr(2'd2, 16'h0100, 1'b0);
    wr(2'd0, 16'h0003, 1'b0);
    repeat (5) @(negedge clk);
    wr(2'd1, 16'h0040, 1'b0);
    rd(2'd1, 1'b0, v); chk("R10 written value", v, 16'h0040);
    @(negedge clk);
    rd(2'd1, 1'b0, v); chk("R10 then decrement", v, 16'h003F);

    // R11 soft reset
    wr(2'd0, 16'h0038, 1'b0);
    @(negedge clk); soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0;
    rd(2'd0, 1'b0, v); chk("R11 mode", v, 0);
    rd(2'd1, 1'b0, v); chk("R11 count", v, 0);
    rd(2'd2, 1'b0, v); chk("R11 reload", v, 0);
    chk("R11 wdog", wdog_user_wr_ok, 1);
    chk("R11 tick", tick, 1);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule